// File: doc/BRIEF.md
# Capture/Compare/PWM Timer Unit

This block runs one free-running 8-bit timer, with a 2-bit sub-count below it, and lets one of three functions use that timer. In capture mode it stores the timer value when a chosen edge pattern arrives on an input pin. In compare mode it raises an interrupt flag when the timer reaches a programmed value. In PWM mode the timer wraps at a programmed 8-bit limit, and a 10-bit duty value is compared against the combined {timer, sub-count} to shape the output waveform.

Software writes four registers through a simple write port. At address 0 is control: bits [1:0] hold the mode (0 idle, 1 capture, 2 compare, 3 PWM), bits [3:2] hold the capture edge (0 falling, 1 rising, 2 every 4th rising, 3 every 16th rising), and bits [5:4] hold the prescale (0 for 1:1, 1 for 1:4, 2 or 3 for 1:16). Address 1 is the PWM period, address 2 is the 10-bit duty and address 3 is the compare value. The timer value is driven on a port of its own so that another peripheral can share it. A short period gives a fast PWM but fewer usable duty steps. With a period of 0 only four duty steps are left, and a duty of 2 gives a plain square wave.

Top module: `ccp_timer_unit`

## Requirements
- R1: While reset is held, tmr_count, cap_value, pwm_out and irq_flag are all 0.
- R2: Outside PWM mode the timer advances once every 4, 16 or 64 clocks for prescale codes 0, 1 and 2.
- R3: tmr_count is the shared timer. Outside PWM mode it counts freely and wraps from 255 to 0.
- R4: In PWM mode with period P the timer counts 0..P, so one PWM cycle lasts 4*(P+1) prescaled ticks.
- R5: In PWM mode pwm_out is high for exactly D ticks of each cycle, where D is the 10-bit duty, counted against {timer, sub-count}.
- R6: A duty above 4*P+3 keeps pwm_out high for the whole cycle. A duty of 0 keeps it low.
- R7: New duty and period values take effect only at the next period boundary, or when control is written.
- R8: Capture with edge code 1 stores the timer on a rising pin edge, and with code 0 on a falling edge. An edge of the other polarity leaves cap_value unchanged.
- R9: Edge codes 2 and 3 store the timer only on every 4th or every 16th rising edge, counted from the last control write.
- R10: In compare mode irq_flag rises in the same cycle in which tmr_count becomes equal to the compare value.
- R11: irq_ack clears irq_flag on the next clock, and takes priority over a new event.
- R12: pwm_out is low whenever the mode is not PWM.
- R13: A write to control restarts the prescaler, sub-count and timer from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 compare |
| wr_data | input | 10 | Write data |
| cap_pin | input | 1 | Asynchronous capture input pin |
| irq_ack | input | 1 | Clears the interrupt flag |
| tmr_count | output | 8 | Shared timer value |
| cap_value | output | 8 | Last captured timer value |
| pwm_out | output | 1 | PWM waveform |
| irq_flag | output | 1 | Capture or compare event flag |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a running PWM cycle, because it must have no effect until the cycle ends. The stimulus uses a 1024-clock cycle with a short duty. It waits for pwm_out to fall, writes a long duty, and confirms that the output stays low for the rest of that cycle before the new width appears. The every-16th-edge capture is also hard to reach. The stimulus pulses the pin once per timer step, so every candidate edge sees a different timer value, and it checks that nothing is stored until the 16th pulse.

// File: rtl/ccp_pkg.sv
package ccp_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE    = 2'd0,
    MODE_CAPTURE = 2'd1,
    MODE_COMPARE = 2'd2,
    MODE_PWM     = 2'd3
  } ccp_mode_e;

  typedef enum logic [1:0] {
    EDGE_FALL   = 2'd0,
    EDGE_RISE   = 2'd1,
    EDGE_RISE_A = 2'd2,
    EDGE_RISE_B = 2'd3
  } edge_sel_e;

  localparam logic [1:0] REG_CTRL    = 2'd0;
  localparam logic [1:0] REG_PERIOD  = 2'd1;
  localparam logic [1:0] REG_DUTY    = 2'd2;
  localparam logic [1:0] REG_COMPARE = 2'd3;
endpackage

// File: rtl/ccp_timebase.sv
module ccp_timebase #(
  parameter int TMR_W   = 8,
  parameter int SUB_W   = 2,
  parameter int PRE_MID = 4,
  parameter int PRE_HI  = 16,
  localparam int FINE_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [1:0]        pre_sel,
  input  logic              pwm_en,
  input  logic [TMR_W-1:0]  period_lim,
  output logic              tick,
  output logic              boundary,
  output logic [FINE_W-1:0] fine_nx,
  output logic [TMR_W-1:0]  tmr
);
  localparam int PRE_W = $clog2(PRE_HI);

  logic [PRE_W-1:0]  pcnt;
  logic [PRE_W-1:0]  lim;
  logic [FINE_W-1:0] fine_q;

  always_comb begin
    case (pre_sel)
      2'd0:    lim = '0;
      2'd1:    lim = PRE_W'(PRE_MID - 1);
      default: lim = PRE_W'(PRE_HI - 1);
    endcase
  end

  assign tick     = (pcnt == lim);
  assign boundary = pwm_en && (fine_q == {period_lim, {SUB_W{1'b1}}});
  assign fine_nx  = boundary ? '0 : fine_q + FINE_W'(1);
  assign tmr      = fine_q[FINE_W-1:SUB_W];

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt   <= '0;
      fine_q <= '0;
    end else begin
      pcnt <= tick ? '0 : pcnt + PRE_W'(1);
      if (tick) fine_q <= fine_nx;
    end
  end
endmodule

// File: rtl/ccp_pwm_gen.sv
module ccp_pwm_gen #(
  parameter int TMR_W   = 8,
  parameter int SUB_W   = 2,
  localparam int FINE_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              en,
  input  logic              tick,
  input  logic              boundary,
  input  logic [FINE_W-1:0] fine_nx,
  input  logic [TMR_W-1:0]  period_buf,
  input  logic [FINE_W-1:0] duty_buf,
  output logic [TMR_W-1:0]  period_act,
  output logic              pwm_out
);
  logic [FINE_W-1:0] duty_act;
  logic [FINE_W-1:0] duty_nx;
  logic              wrap;
  logic              load;

  assign wrap    = tick && boundary;
  assign load    = restart || !en || wrap;
  assign duty_nx = wrap ? duty_buf : duty_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      period_act <= '0;
      duty_act   <= '0;
      pwm_out    <= 1'b0;
    end else begin
      if (load) begin
        period_act <= period_buf;
        duty_act   <= duty_buf;
      end
      if (restart || !en) pwm_out <= 1'b0;
      else if (tick)      pwm_out <= (fine_nx < duty_nx);
    end
  end
endmodule

// File: rtl/ccp_capture_unit.sv
module ccp_capture_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int SYNC_N = 2,
  parameter int EDGE_A = 4,
  parameter int EDGE_B = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             en,
  input  logic [1:0]       edge_sel,
  input  logic             pin,
  input  logic [TMR_W-1:0] tmr,
  output logic [TMR_W-1:0] cap_q,
  output logic             evt_q
);
  localparam int CNT_W = $clog2(EDGE_B);

  logic [SYNC_N:0]  sh;
  logic [CNT_W-1:0] ecnt;
  logic             rise;
  logic             fall;
  logic             hit;

  assign rise = sh[SYNC_N-1] & ~sh[SYNC_N];
  assign fall = ~sh[SYNC_N-1] & sh[SYNC_N];

  always_comb begin
    case (edge_sel)
      EDGE_FALL:   hit = fall;
      EDGE_RISE:   hit = rise;
      EDGE_RISE_A: hit = rise && (ecnt == CNT_W'(EDGE_A - 1));
      default:     hit = rise && (ecnt == CNT_W'(EDGE_B - 1));
    endcase
    hit = hit && en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      ecnt  <= '0;
      cap_q <= '0;
      evt_q <= 1'b0;
    end else begin
      sh    <= {sh[SYNC_N-1:0], pin};
      evt_q <= hit;
      if (hit) cap_q <= tmr;
      if (restart)           ecnt <= '0;
      else if (hit)          ecnt <= '0;
      else if (en && rise)   ecnt <= ecnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/ccp_timer_unit.sv
module ccp_timer_unit
  import ccp_pkg::*;
#(
  parameter int TMR_W   = 8,
  parameter int SUB_W   = 2,
  parameter int PRE_MID = 4,
  parameter int PRE_HI  = 16,
  parameter int EDGE_A  = 4,
  parameter int EDGE_B  = 16,
  parameter int SYNC_N  = 2,
  localparam int FINE_W = TMR_W + SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [FINE_W-1:0] wr_data,
  input  logic              cap_pin,
  input  logic              irq_ack,
  output logic [TMR_W-1:0]  tmr_count,
  output logic [TMR_W-1:0]  cap_value,
  output logic              pwm_out,
  output logic              irq_flag
);
  logic [1:0]        mode_q;
  logic [1:0]        edge_q;
  logic [1:0]        pre_q;
  logic [TMR_W-1:0]  period_buf;
  logic [FINE_W-1:0] duty_buf;
  logic [TMR_W-1:0]  cmp_q;
  logic [TMR_W-1:0]  period_act;
  logic              restart;
  logic              tick;
  logic              boundary;
  logic [FINE_W-1:0] fine_nx;
  logic              cap_evt;
  logic              cmp_hit;
  logic              pwm_en;

  assign restart = wr_en && (wr_addr == REG_CTRL);
  assign pwm_en  = (mode_q == MODE_PWM);
  assign cmp_hit = (mode_q == MODE_COMPARE) && tick &&
                   (fine_nx == {cmp_q, {SUB_W{1'b0}}});

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= MODE_IDLE;
      edge_q     <= '0;
      pre_q      <= '0;
      period_buf <= '0;
      duty_buf   <= '0;
      cmp_q      <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL: begin
          mode_q <= wr_data[1:0];
          edge_q <= wr_data[3:2];
          pre_q  <= wr_data[5:4];
        end
        REG_PERIOD:  period_buf <= wr_data[TMR_W-1:0];
        REG_DUTY:    duty_buf   <= wr_data;
        default:     cmp_q      <= wr_data[TMR_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     irq_flag <= 1'b0;
    else if (irq_ack)            irq_flag <= 1'b0;
    else if (cmp_hit || cap_evt) irq_flag <= 1'b1;
  end

  ccp_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W), .PRE_MID(PRE_MID), .PRE_HI(PRE_HI)) u_tb (
    .clk(clk), .rst(rst), .restart(restart), .pre_sel(pre_q), .pwm_en(pwm_en),
    .period_lim(period_act), .tick(tick), .boundary(boundary), .fine_nx(fine_nx),
    .tmr(tmr_count)
  );

  ccp_pwm_gen #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_pwm (
    .clk(clk), .rst(rst), .restart(restart), .en(pwm_en), .tick(tick),
    .boundary(boundary), .fine_nx(fine_nx), .period_buf(period_buf),
    .duty_buf(duty_buf), .period_act(period_act), .pwm_out(pwm_out)
  );

  ccp_capture_unit #(.TMR_W(TMR_W), .SYNC_N(SYNC_N), .EDGE_A(EDGE_A), .EDGE_B(EDGE_B)) u_cap (
    .clk(clk), .rst(rst), .restart(restart), .en(mode_q == MODE_CAPTURE),
    .edge_sel(edge_q), .pin(cap_pin), .tmr(tmr_count), .cap_q(cap_value),
    .evt_q(cap_evt)
  );
endmodule

// File: rtl/ccp_timer_unit_chk.sv
module ccp_timer_unit_chk
  import ccp_pkg::*;
#(
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode,
  input logic [TMR_W-1:0] cmp,
  input logic [TMR_W-1:0] period_act,
  input logic [TMR_W-1:0] tmr_count,
  input logic [TMR_W-1:0] cap_value,
  input logic             pwm_out,
  input logic             irq_ack,
  input logic             irq_flag
);
  // R12
  pwm_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_PWM) |=> !pwm_out);

  // R11
  irq_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_flag);

  // R4
  tmr_within_period_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_PWM) |-> (tmr_count <= period_act));

  // R8
  cap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != MODE_CAPTURE) |=> $stable(cap_value));

  // R10
  cmp_match_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(irq_flag) && $past(mode) == MODE_COMPARE) |-> (tmr_count == $past(cmp)));
endmodule

bind ccp_timer_unit ccp_timer_unit_chk #(.TMR_W(TMR_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode_q), .cmp(cmp_q), .period_act(period_act),
  .tmr_count(tmr_count), .cap_value(cap_value), .pwm_out(pwm_out),
  .irq_ack(irq_ack), .irq_flag(irq_flag)
);

// File: tb/sim_ccp_timer_unit.sv
module sim_ccp_timer_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = 10'd0;
  logic       cap_pin = 1'b0;
  logic       irq_ack = 1'b0;
  logic [7:0] tmr_count;
  logic [7:0] cap_value;
  logic       pwm_out;
  logic       irq_flag;

  int n_run  = 0;
  int n_fail = 0;
  int    exp_q[$];
  string tag_q[$];
  int    act_q[$];

  always #4 clk = ~clk;

  ccp_timer_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cap_pin(cap_pin), .irq_ack(irq_ack), .tmr_count(tmr_count),
    .cap_value(cap_value), .pwm_out(pwm_out), .irq_flag(irq_flag)
  );

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        int a;
        int e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_run++;
        if (a != e) begin
          n_fail++;
          $display("FAIL %s: actual %0d expected %0d", t, a, e);
        end
      end
    end
  end

  task automatic expect_val(input string t, input int e);
    tag_q.push_back(t);
    exp_q.push_back(e);
  endtask

  task automatic chk(input string t, input int e, input int a);
    expect_val(t, e);
    act_q.push_back(a);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = 10'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int ctrl(input int mode, input int edg, input int pre);
    return (pre << 4) | (edg << 2) | mode;
  endfunction

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic step_len(output int n);
    logic [7:0] t;
    t = tmr_count;
    n = 0;
    while (tmr_count == t && n < 2000) begin @(negedge clk); n++; end
    t = tmr_count;
    n = 0;
    while (tmr_count == t && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_tmr_change();
    logic [7:0] t;
    int n;
    t = tmr_count;
    n = 0;
    while (tmr_count == t && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic count_high(input int len, output int c);
    c = 0;
    for (int i = 0; i < len; i++) begin @(negedge clk); if (pwm_out) c++; end
  endtask

  task automatic count_rises(input int len, output int r, output int mx);
    logic p;
    p = pwm_out; r = 0; mx = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out && !p) r++;
      if (int'(tmr_count) > mx) mx = int'(tmr_count);
      p = pwm_out;
    end
  endtask

  task automatic wait_pwm(input logic lvl);
    int n;
    n = 0;
    while (pwm_out != lvl && n < 3000) begin @(negedge clk); n++; end
  endtask

  task automatic pulse_pin();
    @(negedge clk); cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    cap_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++; n_run++;
      $display("FAIL scoreboard: actual %0d unmatched expected %0d", 0, exp_q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++; n_run++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int v;
    int r;
    int mx;
    int tcap;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk("R1 tmr", 0, tmr_count);
    chk("R1 cap", 0, cap_value);
    chk("R1 pwm", 0, pwm_out);
    chk("R1 irq", 0, irq_flag);
    rst = 1'b0;

    // R2 prescale step lengths
    wr(2'd0, ctrl(0, 0, 0)); step_len(v); chk("R2 prescale 1", 4, v);
    wr(2'd0, ctrl(0, 0, 1)); step_len(v); chk("R2 prescale 4", 16, v);
    wr(2'd0, ctrl(0, 0, 2)); step_len(v); chk("R2 prescale 16", 64, v);

    // R3 wrap, R13 restart
    wr(2'd0, ctrl(0, 0, 0));
    v = 0;
    while (tmr_count != 8'd255 && v < 1200) begin @(negedge clk); v++; end
    wait_tmr_change();
    chk("R3 wrap to 0", 0, tmr_count);
    repeat (60) @(negedge clk);
    wr(2'd0, ctrl(0, 0, 0));
    chk("R13 restart clears timer", 0, tmr_count);

    // R4 / R5 PWM period 3 duty 6
    wr(2'd1, 3); wr(2'd2, 6); wr(2'd0, ctrl(3, 0, 0));
    repeat (40) @(negedge clk);
    count_high(64, v); chk("R5 duty 6 of 16", 24, v);
    count_rises(64, r, mx); chk("R4 period rises", 4, r); chk("R4 timer max", 3, mx);

    // R6 duty beyond period, duty zero
    wr(2'd2, 100); repeat (40) @(negedge clk);
    count_high(64, v); chk("R6 full high", 64, v);
    wr(2'd2, 0); repeat (40) @(negedge clk);
    count_high(64, v); chk("R6 duty zero low", 0, v);

    // R4 / R5 fastest rate: square wave
    wr(2'd1, 0); wr(2'd2, 2); repeat (40) @(negedge clk);
    count_high(64, v); chk("R5 square high count", 32, v);
    count_rises(64, r, mx); chk("R4 square rises", 16, r);

    // R7 double buffer
    wr(2'd1, 255); wr(2'd2, 100); wr(2'd0, ctrl(3, 0, 0));
    wait_pwm(1'b1); wait_pwm(1'b0);
    wr(2'd2, 900);
    count_high(700, v); chk("R7 duty held until boundary", 0, v);
    wait_pwm(1'b1);
    count_high(1024, v); chk("R7 new duty after boundary", 900, v);

    // R12 PWM off outside mode
    wr(2'd0, ctrl(0, 0, 0)); repeat (2) @(negedge clk);
    count_high(100, v); chk("R12 idle output low", 0, v);

    // R8 rising capture
    wr(2'd0, ctrl(1, 1, 2)); ack();
    wait_tmr_change(); wait_tmr_change();
    tcap = tmr_count; cap_pin = 1'b1; repeat (8) @(negedge clk);
    chk("R8 rising capture", tcap, cap_value);
    chk("R8 irq on capture", 1, irq_flag);
    wait_tmr_change(); cap_pin = 1'b0; repeat (8) @(negedge clk);
    chk("R8 falling ignored in rising mode", tcap, cap_value);
    // R8 falling capture
    wr(2'd0, ctrl(1, 0, 2));
    wait_tmr_change(); wait_tmr_change(); wait_tmr_change();
    cap_pin = 1'b1; repeat (8) @(negedge clk);
    chk("R8 rising ignored in falling mode", tcap, cap_value);
    wait_tmr_change(); tcap = tmr_count; cap_pin = 1'b0; repeat (8) @(negedge clk);
    chk("R8 falling capture", tcap, cap_value);

    // R9 every 4th rising
    wr(2'd0, ctrl(1, 2, 2));
    for (int k = 1; k <= 4; k++) begin
      wait_tmr_change();
      if (k == 4) v = tmr_count;
      pulse_pin();
      if (k == 3) chk("R9 no capture before 4th", tcap, cap_value);
    end
    chk("R9 capture on 4th", v, cap_value);
    tcap = v;
    // R9 every 16th rising
    wr(2'd0, ctrl(1, 3, 2));
    for (int k = 1; k <= 16; k++) begin
      wait_tmr_change();
      if (k == 16) v = tmr_count;
      pulse_pin();
      if (k == 15) chk("R9 no capture before 16th", tcap, cap_value);
    end
    chk("R9 capture on 16th", v, cap_value);

    // R10 / R11 compare
    wr(2'd3, 50); wr(2'd0, ctrl(2, 0, 0)); ack();
    chk("R11 flag cleared", 0, irq_flag);
    v = 0;
    while (!irq_flag && v < 3000) begin @(negedge clk); v++; end
    chk("R10 flag with timer at compare", 50, tmr_count);
    ack();
    chk("R11 ack clears compare flag", 0, irq_flag);

    finish_run();
  end
endmodule